// File: doc/BRIEF.md
# SONET Frame-Aligning Receive Deserializer

This block turns a retimed serial bit stream, clocked by its recovered bit clock, into 16-bit parallel words. It watches every bit position for the SONET/SDH framing pattern: three A1 bytes and then one A2 byte. It raises a frame pulse whenever that 32-bit pattern appears, and it can lock its word boundary to the pattern. The A1 byte is 0xF6, the A2 byte is 0x28, and bits arrive most significant bit first.

A boundary search is armed by a rising edge on the out-of-frame request while frame-enable is high. The search ends itself on the first match. When the boundary locks, the word holding the last A1 byte and the A2 byte is aligned, with A2 in the low byte. From then on every 16 received bits are gathered into a holding register. A free-running parallel clock copies the holding register, together with a data-valid flag, into the output register on each of its falling edges. While frame-enable is low, the boundary stays where the last enabled search put it.

Top module: `sonet_frame_deser`

## Requirements
- R1: `frm_pulse` is high during the bit-clock cycle that follows the edge which shifted in the last bit of the sequence F6 F6 F6 28 (MSB first). It is low otherwise, whatever the state of enable and search.
- R2: A search is armed only at a bit-clock edge where `oof_req` is 1, `oof_req` was 0 at the previous edge, and `frm_en` is 1. Holding `oof_req` high does not re-arm a search, and a rising edge while `frm_en` is 0 has no effect.
- R3: During a search, the first pattern match seen with `frm_en` high locks the boundary and ends the search. At that same edge the holding register takes 0xF628, and every later word is taken exactly 16 bits after the previous one.
- R4: Data-valid is cleared at the edge that arms a search. It stays low until the lock edge, and from the lock edge onwards the holding-side flag is high.
- R5: While `frm_en` is 0, the boundary offset does not change. If `frm_en` drops during a search, the search is abandoned without locking: words keep loading at the old boundary and data-valid stays low.
- R6: A pattern match while no search is in progress pulses `frm_pulse` but does not move the boundary.
- R7: On each falling edge of `par_clk`, `rx_word` and `rx_vld` take the holding register and the holding-side valid flag. They hold those values until the next falling edge.
- R8: After reset, `rx_word` is 0, `rx_vld` is 0, `frm_pulse` is 0, no search is pending and the boundary offset is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Recovered serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Retimed serial data, sampled on the rising edge of `clk_bit` |
| frm_en | input | 1 | Frame-enable level; allows searches and boundary changes |
| oof_req | input | 1 | Out-of-frame request; a rising edge arms a search |
| par_clk | input | 1 | Free-running parallel output clock; output loads on its falling edge |
| rx_word | output | 16 | Aligned parallel output word, first received bit in bit 15 |
| rx_vld | output | 1 | Output word is aligned to a locked boundary |
| frm_pulse | output | 1 | Framing pattern seen in the last 32 received bits |

## Verification
The bench builds the block with its default values: a 16-bit word, three A1 bytes of 0xF6 and an A2 byte of 0x28. The pattern is twice the word width, and the preamble lengths are odd, so locks fall on several different offsets between 0 and 15. The bench also inserts single bytes that shift the pattern by half a word against an existing lock. This separates a frozen boundary from a moved one, because the bytes of a known fill word come out swapped. The parallel clock is one sixteenth of the bit rate, with a phase that keeps its falling edges clear of bit-clock edges. As a result, the output samples holding-register words loaded at every lock offset.

// File: rtl/sfd_pkg.sv
`timescale 1ns/1ps
package sfd_pkg;

  // Strobes produced by the alignment controller for one bit-clock edge
  typedef struct packed {
    logic start;   // search armed this edge
    logic lock;    // boundary captured this edge
    logic load;    // holding register loads this edge
  } sfd_evt_t;

  // Bit counter step with explicit wrap at the word width
  function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // Expected value of framing byte idx (0 = first transmitted)
  function automatic logic [7:0] pattern_byte(int unsigned idx, int unsigned n_a1,
                                              logic [7:0] a1, logic [7:0] a2);
    return (idx < n_a1) ? a1 : a2;
  endfunction

endpackage

// File: rtl/sfd_pattern_det.sv
`timescale 1ns/1ps
module sfd_pattern_det #(
  parameter logic [7:0] A1_BYTE  = 8'hF6,
  parameter logic [7:0] A2_BYTE  = 8'h28,
  parameter int unsigned A1_COUNT = 3,
  localparam int unsigned N_BYTES = A1_COUNT + 1,
  localparam int unsigned PAT_W   = 8 * N_BYTES
) (
  input  logic             clk_bit,
  input  logic             rst_n,
  input  logic             ser_in,
  output logic [PAT_W-1:0] window,
  output logic             match
);

  logic [PAT_W-1:0]   win_q;
  logic [N_BYTES-1:0] byte_hit;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= {win_q[PAT_W-2:0], ser_in};
  end

  // one comparator per framing byte; oldest byte sits at the top of the window
  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    assign byte_hit[i] =
      (win_q[PAT_W-1-8*i -: 8] == sfd_pkg::pattern_byte(i, A1_COUNT, A1_BYTE, A2_BYTE));
  end

  assign match  = &byte_hit;
  assign window = win_q;

  // R1: a match can only follow a received bit equal to the last bit of A2
  p_fp_tail_r1: assert property (@(posedge clk_bit) disable iff (!rst_n)
    match |-> ($past(ser_in) == A2_BYTE[0]));

endmodule

// File: rtl/sfd_align_ctrl.sv
`timescale 1ns/1ps
module sfd_align_ctrl #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned CW    = $clog2(WORD_W)
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              frm_en,
  input  logic              oof_req,
  input  logic              match,
  output sfd_pkg::sfd_evt_t evt,
  output logic              searching,
  output logic              locked,
  output logic [CW-1:0]     offset
);

  logic          oof_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] off_q;
  logic          search_q;
  logic          locked_q;
  logic          arm_ev;
  logic          lock_ev;
  logic          drop_ev;
  logic          load_ev;

  assign arm_ev  = oof_req & ~oof_q & frm_en;
  assign lock_ev = search_q & match & frm_en & ~arm_ev;
  assign drop_ev = search_q & ~frm_en;
  assign load_ev = lock_ev | (~search_q & (cnt_q == off_q));

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      oof_q    <= 1'b0;
      cnt_q    <= '0;
      off_q    <= '0;
      search_q <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      oof_q <= oof_req;
      cnt_q <= CW'(sfd_pkg::wrap_inc(int'(cnt_q), WORD_W));
      if (lock_ev) off_q <= cnt_q;
      if (arm_ev) begin
        search_q <= 1'b1;
        locked_q <= 1'b0;
      end else if (lock_ev) begin
        search_q <= 1'b0;
        locked_q <= 1'b1;
      end else if (drop_ev) begin
        search_q <= 1'b0;
      end
    end
  end

  assign evt.start = arm_ev;
  assign evt.lock  = lock_ev;
  assign evt.load  = load_ev;
  assign searching = search_q;
  assign locked    = locked_q;
  assign offset    = off_q;

  // R2: without enable, an idle controller stays idle
  p_arm_needs_enable_r2: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (!search_q && !frm_en) |=> !search_q);

  // R3: a qualified match ends the search and marks the boundary locked
  p_lock_ends_search_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (search_q && match && frm_en && !$rose(oof_req)) |=> (!search_q && locked_q));

  // R4: valid is never high while a search is pending
  p_valid_low_in_search_r4: assert property (@(posedge clk_bit) disable iff (!rst_n)
    search_q |-> !locked_q);

  // R5: the boundary is frozen while enable is low
  p_frozen_offset_r5: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !frm_en |=> $stable(off_q));

  // R6: a match outside a search leaves the boundary alone
  p_match_keeps_offset_r6: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (!search_q && match) |=> $stable(off_q));

endmodule

// File: rtl/sfd_word_path.sv
`timescale 1ns/1ps
module sfd_word_path #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              load,
  input  logic              hold_vld,
  input  logic              par_clk,
  output logic [WORD_W-1:0] hold_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_vld
);

  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] hold_q;
  logic [WORD_W-1:0] out_q;
  logic              vld_q;

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      hold_q  <= '0;
    end else begin
      shift_q <= {shift_q[WORD_W-2:0], ser_in};
      if (load) hold_q <= shift_q;
    end
  end

  // output stage in the parallel clock domain, loaded on its falling edge
  always_ff @(negedge par_clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      out_q <= hold_q;
      vld_q <= hold_vld;
    end
  end

  assign hold_word = hold_q;
  assign rx_word   = out_q;
  assign rx_vld    = vld_q;

  // R7: the output shows what the holding register had at the previous falling edge
  p_out_follows_hold_r7: assert property (@(negedge par_clk) disable iff (!rst_n)
    (out_q == $past(hold_q)) && (vld_q == $past(hold_vld)));

endmodule

// File: rtl/sonet_frame_deser.sv
`timescale 1ns/1ps
module sonet_frame_deser #(
  parameter int unsigned WORD_W   = 16,
  parameter logic [7:0]  A1_BYTE  = 8'hF6,
  parameter logic [7:0]  A2_BYTE  = 8'h28,
  parameter int unsigned A1_COUNT = 3,
  localparam int unsigned PAT_W   = 8 * (A1_COUNT + 1),
  localparam int unsigned CW      = $clog2(WORD_W),
  localparam logic [PAT_W-1:0] PATTERN = {{A1_COUNT{A1_BYTE}}, A2_BYTE}
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              ser_in,
  input  logic              frm_en,
  input  logic              oof_req,
  input  logic              par_clk,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_vld,
  output logic              frm_pulse
);

  logic [PAT_W-1:0]  window;
  logic              match;
  sfd_pkg::sfd_evt_t evt;
  logic              searching;
  logic              locked;
  logic [CW-1:0]     offset;
  logic [WORD_W-1:0] hold_word;

  sfd_pattern_det #(
    .A1_BYTE (A1_BYTE),
    .A2_BYTE (A2_BYTE),
    .A1_COUNT(A1_COUNT)
  ) u_det (
    .clk_bit(clk_bit),
    .rst_n  (rst_n),
    .ser_in (ser_in),
    .window (window),
    .match  (match)
  );

  sfd_align_ctrl #(
    .WORD_W(WORD_W)
  ) u_ctrl (
    .clk_bit  (clk_bit),
    .rst_n    (rst_n),
    .frm_en   (frm_en),
    .oof_req  (oof_req),
    .match    (match),
    .evt      (evt),
    .searching(searching),
    .locked   (locked),
    .offset   (offset)
  );

  sfd_word_path #(
    .WORD_W(WORD_W)
  ) u_path (
    .clk_bit  (clk_bit),
    .rst_n    (rst_n),
    .ser_in   (ser_in),
    .load     (evt.load),
    .hold_vld (locked),
    .par_clk  (par_clk),
    .hold_word(hold_word),
    .rx_word  (rx_word),
    .rx_vld   (rx_vld)
  );

  assign frm_pulse = match;

  // R3: the lock edge places the tail of the pattern in the holding register
  p_hold_aligned_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
    evt.lock |=> (hold_word == PATTERN[WORD_W-1:0]));

  // R3: the lock is taken where the full pattern sits in the window
  p_lock_on_window_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
    evt.lock |-> (window == PATTERN));

  // R4: arming a search drops the valid flag at the next edge
  p_start_drops_valid_r4: assert property (@(posedge clk_bit) disable iff (!rst_n)
    evt.start |=> (!locked && searching));

  // R5: once the offset moves, the previous edge was a lock with enable high
  p_offset_moves_on_lock_r5: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !$stable(offset) |-> $past(evt.lock && frm_en));

endmodule

// File: tb/sonet_frame_deser_bench.sv
`timescale 1ns/1ps
module sonet_frame_deser_bench;

  localparam logic [31:0] FRAME = 32'hF6F6F628;

  logic        clk_bit = 1'b0;
  logic        par_clk = 1'b1;
  logic        rst_n   = 1'b0;
  logic        ser_in  = 1'b0;
  logic        frm_en  = 1'b0;
  logic        oof_req = 1'b0;
  logic [15:0] rx_word;
  logic        rx_vld;
  logic        frm_pulse;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  sonet_frame_deser u_sonet_frame_deser (
    .clk_bit  (clk_bit),
    .rst_n    (rst_n),
    .ser_in   (ser_in),
    .frm_en   (frm_en),
    .oof_req  (oof_req),
    .par_clk  (par_clk),
    .rx_word  (rx_word),
    .rx_vld   (rx_vld),
    .frm_pulse(frm_pulse)
  );

  always #2.5 clk_bit = ~clk_bit;

  // parallel clock: bit rate / 16, falling edges kept clear of bit-clock edges
  initial begin
    #1.25;
    forever begin
      par_clk = 1'b1; #40;
      par_clk = 1'b0; #40;
    end
  end

  // ---------------- behavioural reference ----------------
  bit          hist[$];
  int          m_cnt = 0;
  int          m_off = 0;
  bit          m_search = 0;
  bit          m_locked = 0;
  bit          m_oof_prev = 0;
  logic [15:0] m_hold = '0;
  logic [15:0] e_word = '0;
  bit          e_vld  = 0;
  bit          ev_start, ev_lock, ev_load;
  logic [31:0] w_now;

  function automatic logic [31:0] recent32();
    logic [31:0] v = '0;
    for (int k = 0; k < 32; k++) v = {v[30:0], hist[hist.size() - 32 + k]};
    return v;
  endfunction

  initial begin
    for (int k = 0; k < 32; k++) hist.push_back(1'b0);
  end

  always @(posedge clk_bit) begin
    if (rst_n) begin
      w_now    = recent32();
      ev_start = oof_req && !m_oof_prev && frm_en;
      ev_lock  = m_search && (w_now == FRAME) && frm_en && !ev_start;
      ev_load  = ev_lock || (!m_search && (m_cnt == m_off));
      if (ev_load) m_hold = w_now[15:0];
      if (ev_lock) m_off = m_cnt;
      if (ev_start) begin
        m_search = 1; m_locked = 0;
      end else if (ev_lock) begin
        m_search = 0; m_locked = 1;
      end else if (m_search && !frm_en) begin
        m_search = 0;
      end
      m_cnt      = (m_cnt + 1) % 16;
      m_oof_prev = oof_req;
      hist.push_back(ser_in);
      void'(hist.pop_front());
    end
  end

  always @(negedge par_clk) begin
    if (rst_n) begin
      e_word = m_hold;
      e_vld  = m_locked;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk_bit) begin
    if (rst_n && !done) begin
      check("R1 frame pulse", {31'd0, frm_pulse}, {31'd0, (recent32() == FRAME)});
      check("R7 output word", {16'd0, rx_word}, {16'd0, e_word});
      check("R4 data valid", {31'd0, rx_vld}, {31'd0, e_vld});
    end
  end

  // ---------------- stimulus ----------------
  logic [15:0] lfsr = 16'hACE1;

  task automatic send_bit(bit b);
    @(negedge clk_bit);
    ser_in = b;
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int k = 7; k >= 0; k--) send_bit(b[k]);
  endtask

  task automatic send_noise(int n);
    for (int k = 0; k < n; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send_bit(lfsr[0]);
    end
  endtask

  task automatic send_frame();
    send_byte(8'hF6); send_byte(8'hF6); send_byte(8'hF6); send_byte(8'h28);
  endtask

  task automatic send_fill(int pairs);
    for (int k = 0; k < pairs; k++) begin
      send_byte(8'hA5); send_byte(8'h5A);
    end
  endtask

  task automatic pulse_oof();
    oof_req = 1'b1;
    send_byte(8'h00);
    oof_req = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk_bit);
    rst_n = 1'b1;
    #0.1;
    // R8: reset state
    check("R8 word after reset", {16'd0, rx_word}, 32'd0);
    check("R8 valid after reset", {31'd0, rx_vld}, 32'd0);
    check("R8 pulse after reset", {31'd0, frm_pulse}, 32'd0);
    send_noise(40);
    check("R8 no valid without a lock", {31'd0, rx_vld}, 32'd0);

    // first lock; oof held high across the lock must not re-arm (R2)
    send_noise(37);
    frm_en  = 1'b1;
    oof_req = 1'b1;
    send_noise(5);
    send_frame();
    send_fill(6);
    check("R3 aligned fill after lock", {16'd0, rx_word}, 32'h0000A55A);
    check("R2 held oof does not re-arm", {31'd0, rx_vld}, 32'd1);
    oof_req = 1'b0;

    // R6: pattern at a half-word shift while locked
    send_byte(8'h11);
    send_frame();
    send_fill(6);
    check("R6 boundary unchanged", {16'd0, rx_word}, 32'h00005AA5);
    check("R6 valid kept", {31'd0, rx_vld}, 32'd1);

    // R2/R5: rising oof with enable low does nothing
    frm_en = 1'b0;
    pulse_oof();
    send_noise(3);
    send_frame();
    send_fill(6);
    check("R2 no arm while disabled", {31'd0, rx_vld}, 32'd1);

    // R4: armed search clears valid, new lock at another offset
    frm_en = 1'b1;
    pulse_oof();
    send_byte(8'h00); send_byte(8'h00); send_byte(8'h00); send_byte(8'h00);
    check("R4 valid low during search", {31'd0, rx_vld}, 32'd0);
    send_noise(11);
    send_frame();
    send_fill(6);
    check("R4 valid after relock", {31'd0, rx_vld}, 32'd1);
    check("R3 fill after relock", {16'd0, rx_word}, 32'h0000A55A);

    // R5: enable dropped mid-search abandons it
    pulse_oof();
    send_byte(8'h00); send_byte(8'h00);
    frm_en = 1'b0;
    send_noise(6);
    send_frame();
    send_fill(6);
    check("R5 abandoned search stays invalid", {31'd0, rx_vld}, 32'd0);

    // re-enable and lock once more
    frm_en = 1'b1;
    pulse_oof();
    send_noise(9);
    send_frame();
    send_fill(6);
    check("R3 lock after abandon", {16'd0, rx_word}, 32'h0000A55A);
    check("R4 valid after final lock", {31'd0, rx_vld}, 32'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule